// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Serializer

This block produces the identification stream that a synchronous smart-memory device returns when the host resets it. The host holds its reset line high and gives one pulse on the serial clock. The block then loads a fixed four-byte identifier and presents it on a serial data output, one bit per following clock pulse. After the last bit it releases the line.

The serial clock and the reset line are plain inputs. Both pass through a synchronizer in the system clock domain, and edges of the serial clock are found by comparing successive synchronized samples. A controller with four states sequences the work. `ST_IDLE` is the state out of system reset. `ST_ARMED` follows a trigger, which is a serial-clock rising edge seen while reset is high. `ST_SEND` runs while the 32 bits go out. `ST_DONE` holds after the last bit. The transitions are these. A trigger moves any state to `ST_ARMED`. A falling edge in `ST_ARMED` moves to `ST_SEND`. A falling edge in `ST_SEND` at the last bit moves to `ST_DONE`. Every other case keeps the state. A new bit is presented after each falling edge, so the host reads it while the next pulse is high.

Top module: `atr_serializer`

## Requirements
- R1: After system reset, `sda_oe` is 0 and `sda_out` is 1. `sda_out` reads 1 whenever `sda_oe` is 0.
- R2: A rising edge of `sclk` while `card_rst` is 1 is a trigger. It starts a new sequence, and `sda_oe` stays 0 for the rest of that pulse.
- R3: After the falling edge of the trigger pulse, `sda_oe` goes to 1 and `sda_out` shows bit 0 of the first byte, which is 0x2C.
- R4: Each later falling edge of `sclk` advances one bit. The bytes go out in the order 0x2C, 0xAA, 0x55, 0xA1, each byte least significant bit first. Bit k of the stream is bit k of the word 0xA155AA2C.
- R5: The falling edge of the 32nd pulse after the trigger drops `sda_oe` to 0. Further pulses without a trigger leave `sda_oe` at 0.
- R6: A trigger in the middle of a sequence restarts it from bit 0 of 0x2C.
- R7: `card_rst` has no effect unless it is already high at a rising edge of `sclk`. Holding it high with no pulse, or raising it while `sclk` is already high, leaves the outputs unchanged and lets a running sequence continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| card_rst | input | 1 | Host reset line, asynchronous |
| sclk | input | 1 | Host serial clock, sampled as data |
| sda_out | output | 1 | Serial data bit, 1 when released |
| sda_oe | output | 1 | Output enable for the data line |

## Verification
The hardest case to reach is a reset line that changes while the serial clock is already high. It looks like a trigger at the pins, but it must not start anything, and it can only be told apart from a real trigger by the order of the two input changes. The driver has a pulse mode that raises `card_rst` only after `sclk` has risen and drops it after the fall. It uses this mode in the middle of a running sequence and checks that the stream carries on. A second trigger ten bits into a sequence covers the restart path. Both the restart and the bit-32 release are checked pulse by pulse against a scoreboard model.

// File: rtl/atr_pkg.sv
package atr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2,
        ST_DONE  = 2'd3
    } atr_state_e;
endpackage

// File: rtl/atr_edge_sync.sv
module atr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic crst_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic crst_lvl
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sclk_sync_q;
    logic [TOP:0] crst_sync_q;
    logic         sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sync_q <= '0;
            crst_sync_q <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_sync_q <= {sclk_sync_q[TOP-1:0], sclk_in};
            crst_sync_q <= {crst_sync_q[TOP-1:0], crst_in};
            sclk_prev_q <= sclk_sync_q[TOP];
        end
    end

    assign sclk_rise = sclk_sync_q[TOP] & ~sclk_prev_q;
    assign sclk_fall = ~sclk_sync_q[TOP] & sclk_prev_q;
    assign crst_lvl  = crst_sync_q[TOP];
endmodule

// File: rtl/atr_shift_reg.sv
module atr_shift_reg #(
    parameter int               WIDTH = 32,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic shift,
    output logic bit_out
);
    logic [WIDTH-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '1;
        end else if (load) begin
            sreg_q <= INIT;
        end else if (shift) begin
            sreg_q <= {1'b1, sreg_q[WIDTH-1:1]};
        end
    end

    assign bit_out = sreg_q[0];
endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
    import atr_pkg::*;
#(
    parameter int BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_rise,
    input  logic sclk_fall,
    input  logic crst_lvl,
    output logic load,
    output logic shift,
    output logic oe
);
    localparam int                CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BITS - 1);

    atr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             trigger;

    assign trigger = sclk_rise & crst_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trigger) begin
            cnt_q <= '0;
        end else if (state_q == ST_SEND && sclk_fall) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (trigger) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: if (sclk_fall) state_d = ST_SEND;
                ST_SEND:  if (sclk_fall && cnt_q == LAST) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        load  = trigger;
        shift = 1'b0;
        oe    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ARMED, ST_DONE: ;
            ST_SEND: begin
                oe    = 1'b1;
                shift = sclk_fall & ~trigger;
            end
            default: ;
        endcase
    end

    // R2
    arm_on_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> (state_q == ST_ARMED && cnt_q == '0));

    // R3
    send_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && sclk_fall) |=> (state_q == ST_SEND && cnt_q == '0));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && !sclk_fall && !trigger) |=> $stable(cnt_q));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !trigger) |=> (state_q == ST_DONE));

    // R7
    no_false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !trigger) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/atr_serializer.sv
module atr_serializer #(
    parameter int                    ID_BYTES    = 4,
    parameter logic [ID_BYTES*8-1:0] ID_WORD     = 32'hA155_AA2C,
    parameter int                    SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_rst,
    input  logic sclk,
    output logic sda_out,
    output logic sda_oe
);
    localparam int BITS = ID_BYTES * 8;

    logic sclk_rise, sclk_fall, crst_lvl;
    logic load, shift, oe, cur_bit;

    atr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk),
        .crst_in   (card_rst),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .crst_lvl  (crst_lvl)
    );

    atr_ctrl #(.BITS(BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .crst_lvl  (crst_lvl),
        .load      (load),
        .shift     (shift),
        .oe        (oe)
    );

    atr_shift_reg #(.WIDTH(BITS), .INIT(ID_WORD)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (shift),
        .bit_out (cur_bit)
    );

    assign sda_oe  = oe;
    assign sda_out = oe ? cur_bit : 1'b1;

    // R1
    released_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_oe |-> sda_out);
endmodule

// File: tb/tb_atr_serializer.sv
module tb_atr_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_CYC   = 10;

    typedef struct {
        logic  oe;
        logic  data;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_rst = 1'b0;
    logic sclk = 1'b0;
    logic sda_out, sda_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    exp_t exp_q[$];
    event sample_ev;

    // model state
    logic [31:0] id_word = {8'hA1, 8'h55, 8'hAA, 8'h2C};
    bit m_armed = 1'b0;
    bit m_active = 1'b0;
    int m_pos = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atr_serializer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .card_rst (card_rst),
        .sclk     (sclk),
        .sda_out  (sda_out),
        .sda_oe   (sda_oe)
    );

    // monitor
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (sda_oe !== e.oe || sda_out !== e.data) begin
                    n_bad++;
                    $display("FAIL %s: actual oe=%b data=%b expected oe=%b data=%b",
                             e.req, sda_oe, sda_out, e.oe, e.data);
                end
            end
        end
    end

    task automatic push_model(input string req);
        exp_t e;
        e.oe   = m_active;
        e.data = m_active ? id_word[m_pos] : 1'b1;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic sample_now();
        @(negedge clk);
        -> sample_ev;
        #1;
    endtask

    // mode 0: plain pulse, 1: trigger pulse, 2: card_rst raised while sclk high
    task automatic pulse(input int mode, input string req);
        if (mode == 1) begin
            card_rst = 1'b1;
            repeat (HALF_CYC) @(posedge clk);
            m_armed  = 1'b1;
            m_active = 1'b0;
        end
        sclk = 1'b1;
        if (mode == 2) begin
            repeat (HALF_CYC/2) @(posedge clk);
            card_rst = 1'b1;
            repeat (HALF_CYC - HALF_CYC/2) @(posedge clk);
        end else begin
            repeat (HALF_CYC) @(posedge clk);
        end
        push_model(req);
        sample_now();
        @(posedge clk);
        sclk = 1'b0;
        if (m_armed) begin
            m_armed  = 1'b0;
            m_active = 1'b1;
            m_pos    = 0;
        end else if (m_active) begin
            m_pos++;
            if (m_pos == 32) m_active = 1'b0;
        end
        repeat (HALF_CYC) @(posedge clk);
        card_rst = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic run_bits(input int n);
        for (int i = 0; i < n; i++) begin
            if (m_active && m_pos == 0) pulse(0, "R3");
            else if (!m_active) pulse(0, "R5");
            else pulse(0, "R4");
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        push_model("R1");
        sample_now();

        // R7: pulses and a held reset line with no trigger
        pulse(0, "R7");
        card_rst = 1'b1;
        repeat (30) @(posedge clk);
        push_model("R7");
        sample_now();
        card_rst = 1'b0;
        repeat (5) @(posedge clk);
        pulse(2, "R7");
        pulse(0, "R7");

        // R2..R5: full sequence
        pulse(1, "R2");
        run_bits(32);
        run_bits(3);

        // R6: restart ten bits in
        pulse(1, "R2");
        run_bits(10);
        pulse(1, "R6");
        pulse(0, "R6");
        run_bits(5);
        // R7: late reset mid-stream is ignored
        pulse(2, "R7");
        pulse(0, "R7");
        run_bits(28);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule